// File: doc/BRIEF.md
# Unaligned Transmit Byte Unpacker

This block turns a transmit payload held in word-wide memory into a byte stream for a serial frame builder. A request gives a byte start pointer and a byte count. The block fetches the payload one 32-bit word at a time through an address channel with a valid/ready handshake. The data comes back on a return channel. The block then delivers the payload one byte at a time on an output channel with a valid/ready handshake.

The start pointer may name any byte. The word address sent to memory is always the pointer with its low two bits cleared. Those two low bits select the first byte lane used in the first word, so they also set how many bytes that word supplies. Bytes leave in strictly ascending address order. The final byte is tagged so that the downstream framer knows where to append its check sequence and closing flag. Flags, CRC and bit stuffing belong to the downstream framer.

Top module: `tx_byte_unpacker`

## Requirements
- R1: After a synchronous active-high reset, the block is idle. In the idle state `req_ready` is 1, while `rd_addr_valid`, `out_valid` and `done` are 0.
- R2: Every word address presented on `rd_addr` has its two low bits at zero and equals the start pointer with those bits cleared. Each later read is 4 higher than the one before. `rd_addr` holds steady while `rd_addr_ready` is low.
- R3: The first output byte comes from byte lane `req_ptr[1:0]` of the first word. That word supplies 4, 3, 2 or 1 bytes for lane offsets 0, 1, 2 and 3, limited by the length.
- R4: Memory is little endian. Byte lane k is `rd_data[8k+7:8k]` and holds address word_address+k. Bytes are emitted in ascending address order with no gaps or repeats.
- R5: When fewer bytes remain than a word could supply, only the remaining bytes are emitted and the upper lanes are discarded. A transfer issues exactly ceil((ptr[1:0]+len)/4) reads.
- R6: `out_last` is 1 on the final byte only. In the cycle after that byte is accepted, `done` is 1 for one cycle and `req_ready` is 1 again.
- R7: A request with length 0 causes no read and no output byte, and `done` is 1 in the cycle after the request is accepted.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.
- R9: No word read is requested while any byte of the previous word is still waiting to be accepted downstream.
- R10: A request is taken only when `req_ready` is 1. A request offered while a transfer is in progress is ignored and does not change the byte stream.
- R11: The return channel is sampled only while a read is outstanding. `rd_data` is captured in the cycle in which `rd_data_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A transfer request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_ptr | input | ADDR_W | Byte start pointer of the payload |
| req_len | input | LEN_W | Payload length in bytes |
| rd_addr_valid | output | 1 | A word read address is offered |
| rd_addr_ready | input | 1 | Memory takes the read address |
| rd_addr | output | ADDR_W | Word-aligned byte address of the read |
| rd_data_valid | input | 1 | Read data is returned |
| rd_data | input | DATA_W | Returned word, lane 0 in bits 7:0 |
| out_valid | output | 1 | An output byte is offered |
| out_ready | input | 1 | Downstream takes the byte |
| out_data | output | 8 | Payload byte |
| out_last | output | 1 | Marks the final payload byte |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
The bench runs every start lane against lengths that end inside the first word, exactly at a word edge, and several words later. A design that mishandles the pointer offset would emit stale low lanes or drop bytes. One that ignores the length would leak upper lanes or issue an extra read. Zero-length requests check that no read starts and that `done` still pulses. Random stalls on the output and on memory expose a byte that is lost or repeated, a read that starts before the last byte of a word has left, and a `done` that comes a cycle early or late. Requests offered while the block is busy must leave the stream unchanged.

// File: rtl/tx_unpack_pkg.sv
package tx_unpack_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2,
    ST_EMIT = 2'd3
  } unpk_state_e;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/tx_unpack_lane_sel.sv
module tx_unpack_lane_sel #(
  parameter int unsigned LANES = 4,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned WORD_W = LANES * tx_unpack_pkg::BYTE_W
) (
  input  logic [WORD_W-1:0]               word_in,
  input  logic [SEL_W-1:0]                lane_sel,
  output logic [tx_unpack_pkg::BYTE_W-1:0] byte_out
);
  import tx_unpack_pkg::*;

  logic [BYTE_W-1:0] lane_bytes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_bytes[g] = word_in[g*BYTE_W +: BYTE_W];
  end

  assign byte_out = lane_bytes[lane_sel];

endmodule

// File: rtl/tx_unpack_cursor.sv
module tx_unpack_cursor #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned SEL_W = $clog2(LANES),
  localparam int unsigned WIDX_W = ADDR_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_ptr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              step,
  output logic [WIDX_W-1:0] word_idx,
  output logic [SEL_W-1:0]  lane,
  output logic              is_final,
  output logic              word_end
);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_idx <= '0;
      lane     <= '0;
      remain   <= '0;
    end else if (load) begin
      word_idx <= load_ptr[ADDR_W-1:SEL_W];
      lane     <= load_ptr[SEL_W-1:0];
      remain   <= load_len;
    end else if (step) begin
      remain <= remain - 1'b1;
      lane   <= lane + 1'b1;
      if (lane == SEL_W'(LANES - 1)) begin
        word_idx <= word_idx + 1'b1;
      end
    end
  end

  assign is_final = (remain == LEN_W'(1));
  assign word_end = (lane == SEL_W'(LANES - 1));

endmodule

// File: rtl/tx_byte_unpacker.sv
module tx_byte_unpacker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_addr_valid,
  input  logic              rd_addr_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done
);
  import tx_unpack_pkg::*;

  localparam int unsigned LANES  = DATA_W / BYTE_W;
  localparam int unsigned SEL_W  = $clog2(LANES);
  localparam int unsigned WIDX_W = ADDR_W - SEL_W;

  unpk_state_e       state;
  logic [DATA_W-1:0] word_buf;
  logic              done_r;

  logic              take_req;
  logic              load;
  logic              step;
  logic [WIDX_W-1:0] word_idx;
  logic [SEL_W-1:0]  lane;
  logic              is_final;
  logic              word_end;

  assign take_req = (state == ST_IDLE) && req_valid;
  assign load     = take_req && (req_len != '0);
  assign step     = (state == ST_EMIT) && out_ready;

  tx_unpack_cursor #(
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_W),
    .LANES (LANES)
  ) u_cursor (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .load_ptr(req_ptr),
    .load_len(req_len),
    .step    (step),
    .word_idx(word_idx),
    .lane    (lane),
    .is_final(is_final),
    .word_end(word_end)
  );

  tx_unpack_lane_sel #(
    .LANES(LANES)
  ) u_lane_sel (
    .word_in (word_buf),
    .lane_sel(lane),
    .byte_out(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      word_buf <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take_req) begin
            if (req_len == '0) begin
              done_r <= 1'b1;
            end else begin
              state <= ST_ADDR;
            end
          end
        end
        ST_ADDR: begin
          if (rd_addr_ready) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rd_data_valid) begin
            word_buf <= rd_data;
            state    <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (is_final) begin
              state  <= ST_IDLE;
              done_r <= 1'b1;
            end else if (word_end) begin
              state <= ST_ADDR;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rd_addr_valid = (state == ST_ADDR);
  assign rd_addr       = {word_idx, {SEL_W{1'b0}}};
  assign out_valid     = (state == ST_EMIT);
  assign out_last      = (state == ST_EMIT) && is_final;
  assign done          = done_r;

endmodule

// File: rtl/tx_byte_unpacker_chk.sv
module tx_byte_unpacker_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LEN_W-1:0]  req_len,
  input logic              rd_addr_valid,
  input logic              rd_addr_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic              out_last,
  input logic              done
);

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !rd_addr_valid && !out_valid && !done));

  assert_word_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    rd_addr_valid |-> (rd_addr[1:0] == 2'b00));

  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_valid && !rd_addr_ready) |=> (rd_addr_valid && $stable(rd_addr)));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (done && req_ready));

  assert_zero_len_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == '0) |=> (done && !rd_addr_valid && !out_valid));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_no_read_while_emitting_R9: assert property (@(posedge clk) disable iff (rst)
    !(rd_addr_valid && out_valid));

  assert_busy_blocks_req_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid || rd_addr_valid) |-> !req_ready);

endmodule

bind tx_byte_unpacker tx_byte_unpacker_chk #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_len      (req_len),
  .rd_addr_valid(rd_addr_valid),
  .rd_addr_ready(rd_addr_ready),
  .rd_addr      (rd_addr),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_last     (out_last),
  .done         (done)
);

// File: tb/tx_byte_unpacker_tb.sv
`timescale 1ns/1ps
module tx_byte_unpacker_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ptr = '0;
  logic [15:0] req_len = '0;
  logic        rd_addr_valid;
  logic        rd_addr_ready = 1'b0;
  logic [31:0] rd_addr;
  logic        rd_data_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        done;

  always #2.5 clk = ~clk;

  tx_byte_unpacker u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_ptr(req_ptr), .req_len(req_len),
    .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_addr(rd_addr),
    .rd_data_valid(rd_data_valid), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [8:0]  exp_q[$];
  logic [31:0] addr_q[$];
  int reads = 0;
  int data_cnt = 0;
  logic [31:0] pend_addr = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit stall_en = 0;
  bit expect_done = 0;
  bit stall_prev = 0;
  logic [7:0] stall_data = '0;
  logic stall_last = 1'b0;

  function automatic logic [7:0] mem_byte(logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {mem_byte(a + 32'd3), mem_byte(a + 32'd2), mem_byte(a + 32'd1), mem_byte(a)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      bit ar;
      bit orr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (expect_done) begin
        chk(done === 1'b1 && req_ready === 1'b1, "R6", "done/idle after last",
            {done, req_ready}, 32'h3);
        expect_done = 0;
      end
      if (stall_prev) begin
        chk(out_valid === 1'b1 && out_data === stall_data && out_last === stall_last,
            "R8", "byte held under stall", {out_valid, out_last, out_data},
            {1'b1, stall_last, stall_data});
      end
      rd_data_valid = 1'b0;
      if (data_cnt > 0) begin
        data_cnt--;
        if (data_cnt == 0) begin
          rd_data_valid = 1'b1;
          rd_data = mem_word(pend_addr);
        end
      end
      ar = stall_en ? lfsr[1] : 1'b1;
      rd_addr_ready = ar;
      if (rd_addr_valid && ar) begin
        logic [31:0] ea;
        reads++;
        chk(out_valid === 1'b0, "R9", "read while byte pending", out_valid, 0);
        ea = (addr_q.size() > 0) ? addr_q.pop_front() : 32'hFFFF_FFFF;
        chk(rd_addr === ea, "R2", "word address", rd_addr, ea);
        pend_addr = rd_addr;
        data_cnt = 1 + ((stall_en && lfsr[2]) ? 1 : 0);
      end
      orr = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
      out_ready = orr;
      stall_prev = out_valid && !orr;
      stall_data = out_data;
      stall_last = out_last;
      if (out_valid && orr) begin
        logic [8:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 9'h1FF;
        chk(out_data === e[7:0], "R4", "byte value/order", out_data, e[7:0]);
        chk(out_last === e[8], "R6", "last marker", out_last, e[8]);
        if (e[8]) expect_done = 1;
      end
    end
  end

  task automatic run(logic [31:0] ptr, logic [15:0] len, bit stl, bit bogus);
    int r0;
    int words;
    int t;
    stall_en = stl;
    while (!req_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      logic [31:0] a;
      a = ptr + i;
      exp_q.push_back({(i == len - 1), mem_byte(a)});
    end
    words = (len == 0) ? 0 : (ptr[1:0] + len + 3) / 4;
    for (int w = 0; w < words; w++) addr_q.push_back({ptr[31:2], 2'b00} + 32'(4 * w));
    r0 = reads;
    req_ptr = ptr;
    req_len = len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done === 1'b1, "R7", "done after zero length", done, 1);
      repeat (4) @(negedge clk);
      chk(reads == r0 && out_valid === 1'b0, "R7", "no read or byte on zero length",
          reads - r0, 0);
    end else begin
      if (bogus) begin
        @(negedge clk);
        chk(req_ready === 1'b0, "R10", "busy refuses request", req_ready, 0);
        req_ptr = ptr + 32'h41;
        req_len = 16'd3;
        req_valid = 1'b1;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
      end
      t = 0;
      while ((exp_q.size() > 0 || expect_done) && t < 5000) begin
        @(negedge clk);
        t++;
      end
      chk(t < 5000, "R4", "transfer completes", t, 0);
      chk(reads - r0 == words, "R5", "read count", reads - r0, words);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && out_valid === 1'b0 && rd_addr_valid === 1'b0 && done === 1'b0,
        "R1", "reset state", {req_ready, out_valid, rd_addr_valid, done}, 32'h8);
    run(32'h0000_0100, 16'd8, 0, 0);   // R3 R4 aligned, two words
    run(32'h0000_0201, 16'd5, 0, 0);   // R3 offset 1
    run(32'h0000_0302, 16'd2, 0, 0);   // R3 offset 2, ends at word edge
    run(32'h0000_0303, 16'd1, 0, 0);   // R3 offset 3, single byte
    run(32'h0000_0401, 16'd2, 0, 0);   // R5 ends inside first word
    run(32'h0000_0502, 16'd0, 0, 0);   // R7 zero length
    run(32'h0000_0603, 16'd9, 1, 0);   // R8 R9 backpressure
    run(32'h0000_0700, 16'd4, 1, 0);   // R5 exactly one word
    run(32'h0000_1001, 16'd37, 1, 1);  // R10 R11 long with stalls and a refused request
    run(32'h0000_2000, 16'd0, 1, 0);   // R7 zero length again
    run(32'h0000_2FFE, 16'd11, 1, 0);  // R2 word crossing
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule